// File: doc/BRIEF.md
# Segment Descriptor Cache and Linear Address Translator

This block keeps a cached copy of one segment descriptor for each of six segment registers. A load port takes a register index, a 16-bit selector and the 8-byte descriptor already fetched for that selector. The block unpacks the split base and limit fields and the attribute bits into the entry for that register. Only that register's entry changes.

On the access port, the requester gives a register index, a 32-bit offset and an access size. One cycle later the block returns the 32-bit linear address. This address is the cached base plus the offset, wrapping modulo 2^32. In the same cycle the block raises a fault flag in three cases: the entry is not loaded, the index does not name a register, or any byte of the access lies beyond the segment's effective limit.

The block also returns the cached selector and attribute bits of the entry it used, so callers can see them. It does not fetch descriptors, check a descriptor when it is loaded, or apply paging.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every entry is invalid, and `res_valid_o`, `fault_o`, `lin_addr_o`, `res_sel_o` and `res_attr_o` are all zero.
- R2: The base is byte 7 (bits 63:56) above bytes 4..2 (bits 39:16) of the descriptor, where byte n is bits 8n+7:8n. `lin_addr_o` equals (base + offset) mod 2^32.
- R3: The 20-bit raw limit is the low nibble of byte 6 (bits 51:48) above bytes 1..0 (bits 15:0). When the granularity bit (bit 55) is 0, the raw limit is the last valid byte offset.
- R4: When bit 55 is 1, the effective limit is the raw limit shifted left by 12 with the low 12 bits set to one.
- R5: `acc_size_i` selects the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The access faults when offset + width - 1, computed without wrap, is greater than the effective limit.
- R6: An access through an entry not loaded since reset, or with an index of 6 or 7, faults. In that case the base, selector and attributes read as zero.
- R7: A load writes only the entry named by `ld_reg_i`. A load with index 6 or 7 changes no entry.
- R8: Results appear on the cycle after `acc_valid_i`, with `res_valid_o` high for exactly that cycle. `fault_o` is low whenever `res_valid_o` is low. The address, selector and attributes hold between accesses.
- R9: `res_sel_o` returns the entry's selector. `res_attr_o` returns {bits 55:52, byte 5}. An access in the same cycle as a load to the same register sees the entry as it was before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | Load strobe |
| ld_reg_i | input | 3 | Register index to load |
| ld_sel_i | input | 16 | Selector being loaded |
| ld_desc_i | input | 64 | Descriptor bytes, byte 0 in bits 7:0 |
| acc_valid_i | input | 1 | Access strobe |
| acc_reg_i | input | 3 | Register index to access |
| acc_off_i | input | 32 | Offset within the segment |
| acc_size_i | input | 2 | Access width code |
| res_valid_o | output | 1 | Result strobe |
| lin_addr_o | output | 32 | Linear address |
| fault_o | output | 1 | Limit or invalid-entry fault |
| res_sel_o | output | 16 | Selector of the entry used |
| res_attr_o | output | 12 | Flag nibble and access byte of the entry used |

## Verification
The assertions assume nothing about the descriptor contents. They do assume that the inputs are settled at each rising edge and that the register indices are known values. The stimulus drives every input on the falling edge. It uses indices 0 to 7 on purpose, so that the out-of-range indices are covered by normal traffic instead of being avoided. The fault-on-unloaded-entry property relies on its own record of which registers have been loaded since reset. The bench therefore also accesses registers before they are loaded, to exercise that path.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int ATTR_W = 12;
  localparam int DESC_W = 64;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_ALT   = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic              valid;
    logic [SEL_W-1:0]  sel;
    logic [ATTR_W-1:0] attr;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] lim;   // effective byte limit, granularity applied
  } seg_entry_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DESC_W-1:0] desc_i,
  output seg_entry_t        ent_o
);
  logic [19:0] raw_lim;
  logic        gran;

  assign raw_lim = {desc_i[51:48], desc_i[15:0]};
  assign gran    = desc_i[55];

  always_comb begin
    ent_o       = '0;
    ent_o.valid = 1'b1;
    ent_o.sel   = sel_i;
    ent_o.attr  = {desc_i[55:52], desc_i[47:40]};
    ent_o.base  = {desc_i[63:56], desc_i[39:16]};
    ent_o.lim   = gran ? {raw_lim, 12'hfff} : {12'h000, raw_lim};
  end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  seg_entry_t       wr_ent_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output seg_entry_t       rd_ent_o
);
  seg_entry_t ent_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))    ent_q[g] <= wr_ent_i;
    end
  end

  // out-of-range index reads an all-zero (invalid) entry
  always_comb begin
    rd_ent_o = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (rd_idx_i == IDX_W'(i)) rd_ent_o = ent_q[i];
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  seg_entry_t        ent_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [1:0]        size_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              fault_o,
  output logic [SEL_W-1:0]  res_sel_o,
  output logic [ATTR_W-1:0] res_attr_o
);
  logic [ADDR_W:0]   span;
  logic [ADDR_W:0]   last_byte;
  logic              over;
  logic              flt;
  logic [ADDR_W-1:0] lin;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_BYTE: span = (ADDR_W+1)'(0);
      SZ_WORD: span = (ADDR_W+1)'(1);
      default: span = (ADDR_W+1)'(3);
    endcase
  end

  // one extra bit so accesses running past 2^32 still compare as over-limit
  assign last_byte = {1'b0, off_i} + span;
  assign over      = last_byte > {1'b0, ent_i.lim};
  assign flt       = !ent_i.valid || over;
  assign lin       = ent_i.base + off_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      fault_o     <= 1'b0;
      lin_addr_o  <= '0;
      res_sel_o   <= '0;
      res_attr_o  <= '0;
    end else begin
      res_valid_o <= acc_valid_i;
      fault_o     <= acc_valid_i && flt;
      if (acc_valid_i) begin
        lin_addr_o <= lin;
        res_sel_o  <= ent_i.sel;
        res_attr_o <= ent_i.attr;
      end
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter  int NUM_SEG = 6,
  localparam int IDX_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [IDX_W-1:0]  ld_reg_i,
  input  logic [SEL_W-1:0]  ld_sel_i,
  input  logic [DESC_W-1:0] ld_desc_i,
  input  logic              acc_valid_i,
  input  logic [IDX_W-1:0]  acc_reg_i,
  input  logic [ADDR_W-1:0] acc_off_i,
  input  logic [1:0]        acc_size_i,
  output logic              res_valid_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              fault_o,
  output logic [SEL_W-1:0]  res_sel_o,
  output logic [ATTR_W-1:0] res_attr_o
);
  seg_entry_t new_ent;
  seg_entry_t rd_ent;

  seg_desc_unpack u_unpack (
    .sel_i  (ld_sel_i),
    .desc_i (ld_desc_i),
    .ent_o  (new_ent)
  );

  seg_cache #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (ld_valid_i),
    .wr_idx_i (ld_reg_i),
    .wr_ent_i (new_ent),
    .rd_idx_i (acc_reg_i),
    .rd_ent_o (rd_ent)
  );

  seg_check u_check (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .ent_i       (rd_ent),
    .off_i       (acc_off_i),
    .size_i      (acc_size_i),
    .res_valid_o (res_valid_o),
    .lin_addr_o  (lin_addr_o),
    .fault_o     (fault_o),
    .res_sel_o   (res_sel_o),
    .res_attr_o  (res_attr_o)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int IDX_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_valid_i,
  input logic [IDX_W-1:0]  ld_reg_i,
  input logic [SEL_W-1:0]  ld_sel_i,
  input logic [DESC_W-1:0] ld_desc_i,
  input logic              acc_valid_i,
  input logic [IDX_W-1:0]  acc_reg_i,
  input logic [ADDR_W-1:0] acc_off_i,
  input logic [1:0]        acc_size_i,
  input logic              res_valid_o,
  input logic [ADDR_W-1:0] lin_addr_o,
  input logic              fault_o,
  input logic [SEL_W-1:0]  res_sel_o,
  input logic [ATTR_W-1:0] res_attr_o
);
  logic [NUM_SEG-1:0] seen_q;
  logic               acc_seen;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seen
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  seen_q[g] <= 1'b0;
      else if (ld_valid_i && ld_reg_i == IDX_W'(g)) seen_q[g] <= 1'b1;
    end
  end

  always_comb begin
    acc_seen = 1'b0;
    for (int i = 0; i < NUM_SEG; i++)
      if (acc_reg_i == IDX_W'(i)) acc_seen = seen_q[i];
  end

  assert_result_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> res_valid_o);
  assert_idle_no_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !res_valid_o);
  assert_fault_needs_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !fault_o);
  assert_addr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(lin_addr_o) && $stable(res_sel_o) && $stable(res_attr_o));
  assert_unloaded_faults_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !acc_seen) |=> fault_o);
endmodule

bind seg_xlate seg_xlate_chk #(.NUM_SEG(NUM_SEG), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
  localparam time CLK_PERIOD = 10ns;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [2:0]  ld_reg_i = '0;
  logic [15:0] ld_sel_i = '0;
  logic [63:0] ld_desc_i = '0;
  logic        acc_valid_i = 1'b0;
  logic [2:0]  acc_reg_i = '0;
  logic [31:0] acc_off_i = '0;
  logic [1:0]  acc_size_i = '0;
  logic        res_valid_o;
  logic [31:0] lin_addr_o;
  logic        fault_o;
  logic [15:0] res_sel_o;
  logic [11:0] res_attr_o;

  seg_xlate dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0;
  int fails = 0;

  // reference model state
  bit          m_val  [8];
  logic [31:0] m_base [8];
  logic [31:0] m_lim  [8];
  logic [15:0] m_sel  [8];
  logic [11:0] m_attr [8];

  bit          e_valid = 0;
  bit          e_fault = 0;
  logic [31:0] e_addr  = '0;
  logic [15:0] e_sel   = '0;
  logic [11:0] e_attr  = '0;
  string       e_tag   = "R1";

  function automatic logic [63:0] mk_desc(logic [31:0] base, logic [19:0] lim,
                                          bit g, logic [7:0] acc);
    return {base[31:24], g, 3'b010, lim[19:16], acc, base[23:0], lim[15:0]};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit ld, logic [2:0] lr, logic [15:0] ls, logic [63:0] d,
                      bit ac, logic [2:0] ar, logic [31:0] off, logic [1:0] sz,
                      string tag);
    longint unsigned last, n;
    @(negedge clk_i);
    chk(res_valid_o == e_valid, "R8", "res_valid", 32'(res_valid_o), 32'(e_valid));
    chk(fault_o == e_fault, e_tag, "fault", 32'(fault_o), 32'(e_fault));
    chk(lin_addr_o == e_addr, e_tag, "lin_addr", lin_addr_o, e_addr);
    chk(res_sel_o == e_sel, "R9", "sel", 32'(res_sel_o), 32'(e_sel));
    chk(res_attr_o == e_attr, "R9", "attr", 32'(res_attr_o), 32'(e_attr));
    ld_valid_i = ld; ld_reg_i = lr; ld_sel_i = ls; ld_desc_i = d;
    acc_valid_i = ac; acc_reg_i = ar; acc_off_i = off; acc_size_i = sz;
    e_valid = ac;
    if (ac) begin
      n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      last = longint'(off) + n - 1;
      e_addr  = m_base[ar] + off;
      e_sel   = m_sel[ar];
      e_attr  = m_attr[ar];
      e_fault = !m_val[ar] || (last > longint'(m_lim[ar]));
      e_tag   = tag;
    end else begin
      e_fault = 0;
    end
    // model update after the read: same-cycle access sees old entry (R9)
    if (ld && lr < 3'd6) begin
      m_val[lr]  = 1;
      m_sel[lr]  = ls;
      m_attr[lr] = {d[55:52], d[47:40]};
      m_base[lr] = {d[63:56], d[39:16]};
      m_lim[lr]  = d[55] ? {d[51:48], d[15:0], 12'hfff} : {12'h000, d[51:48], d[15:0]};
    end
  endtask

  task automatic load(logic [2:0] r, logic [15:0] s, logic [63:0] d);
    step(1, r, s, d, 0, 0, 0, 0, "R7");
  endtask

  task automatic acc(logic [2:0] r, logic [31:0] off, logic [1:0] sz, string tag);
    step(0, 0, 0, 0, 1, r, off, sz, tag);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, "R8");
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_val[i] = 0; m_base[i] = '0; m_lim[i] = '0; m_sel[i] = '0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    idle(); idle();                          // R1 reset state
    acc(3'd3, 32'h10, 2'd0, "R6");           // unloaded entry
    idle();
    // R2/R3: byte limit 0xFFF
    load(3'd3, 16'h0023, mk_desc(32'h1234_5678, 20'h00fff, 0, 8'h93));
    acc(3'd3, 32'h10, 2'd0, "R2");
    acc(3'd3, 32'hfff, 2'd0, "R3");
    acc(3'd3, 32'h1000, 2'd0, "R3");
    acc(3'd3, 32'hffe, 2'd1, "R5");
    acc(3'd3, 32'hfff, 2'd1, "R5");
    acc(3'd3, 32'hffc, 2'd2, "R5");
    acc(3'd3, 32'hffd, 2'd2, "R5");
    acc(3'd3, 32'hffd, 2'd3, "R5");
    idle();
    // R4: page granularity, address wrap (R2)
    load(3'd0, 16'h0008, mk_desc(32'hffff_f000, 20'h00002, 1, 8'h9b));
    acc(3'd0, 32'h2fff, 2'd0, "R4");
    acc(3'd0, 32'h3000, 2'd0, "R4");
    acc(3'd0, 32'h2000, 2'd1, "R2");
    // R5: full 4 GiB segment, last-byte past 2^32
    load(3'd2, 16'h0010, mk_desc(32'h0000_0100, 20'hfffff, 1, 8'h93));
    acc(3'd2, 32'hffff_fffc, 2'd2, "R5");
    acc(3'd2, 32'hffff_fffd, 2'd2, "R5");
    acc(3'd2, 32'hffff_ffff, 2'd0, "R5");
    acc(3'd2, 32'hffff_ffff, 2'd1, "R5");
    // R7: out-of-range load ignored, other entries untouched
    load(3'd6, 16'h0030, mk_desc(32'h5555_0000, 20'hfffff, 0, 8'h93));
    acc(3'd6, 32'h0, 2'd0, "R6");
    acc(3'd7, 32'h4, 2'd0, "R6");
    load(3'd5, 16'h0038, mk_desc(32'h0abc_0000, 20'h0000f, 0, 8'hf3));
    acc(3'd3, 32'h20, 2'd0, "R7");
    acc(3'd5, 32'h0f, 2'd0, "R7");
    acc(3'd5, 32'h10, 2'd0, "R7");
    // R9: same-cycle load and access see the old entry
    step(1, 3'd3, 16'h0043, mk_desc(32'h2000_0000, 20'h000ff, 0, 8'h91),
         1, 3'd3, 32'h200, 2'd0, "R9");
    acc(3'd3, 32'h200, 2'd0, "R9");
    acc(3'd3, 32'h0ff, 2'd0, "R9");
    idle(); idle();
    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      automatic logic [2:0] r = 3'($urandom_range(0, 7));
      automatic logic [31:0] lim = 32'($urandom_range(0, 20'hfffff));
      if ((k % 4) == 0)
        load(r, 16'($urandom), mk_desc($urandom, lim[19:0], bit'($urandom_range(0, 1)),
                                       8'($urandom)));
      else if ((k % 7) == 0)
        idle();
      else
        acc(r, (k % 3 == 0) ? $urandom : 32'($urandom_range(0, 32'h2000)),
            2'($urandom_range(0, 3)), "R2");
    end
    idle(); idle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule